// File: doc/BRIEF.md
# Flash Write-Gating and Ready/Busy Controller

This block is the control front end of a parallel flash memory. Each system clock it samples the chip-enable, output-enable and write-enable strobes. It decides whether a bus cycle is a real write, and it rejects strobe pulses too short to be genuine. While the supply-low flag is raised it holds the whole command path idle in read-array mode. Qualified writes step a three-cycle unlock sequence. A completed sequence for program or erase emits a one-clock start pulse carrying the command type to the program/erase engine, which lies outside this block.

The block also drives an open-drain ready/busy line, given as a pull-low enable. The line is pulled low from the moment a program or erase command is accepted until the engine reports it is done. It is released while the engine is suspended or powered down. Chip enable and output enable have no effect on it, so several devices can share one wired line with a pull-up resistor. The strobes and flags are assumed to be synchronous to the clock.

Top module: `flash_wr_gate`

## Requirements
- R1: A write is recognised only while ce_n=0, we_n=0 and oe_n=1. A strobe cycle with oe_n low, or with ce_n high, has no effect on mode, start or ready/busy.
- R2: A write is accepted only if its qualifying condition holds for at least GLITCH_CYC consecutive clock samples (default 2). Shorter pulses are ignored. Address and data are taken from the last qualifying sample, and the write takes effect when the condition ends.
- R3: While low_vcc=1, mode returns to read (0), the busy state and any partial sequence are cleared, start stays low, and all writes are ignored.
- R4: After synchronous reset (rst_n=0), mode is read (0), start is low and rb_pull_en is low.
- R5: The sequence is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then a command byte at 0x5555. A command byte of 0xA0 issues start with start_cmd=0 (program) and sets mode=1. A command byte of 0x80 issues start with start_cmd=1 (erase) and sets mode=2. Either command enters the busy state.
- R6: A cycle that does not match the expected step returns the sequence to its first step without being reinterpreted. A command byte that is not recognised issues no start. Command byte 0xF0 returns mode to read with no start.
- R7: start is high for exactly one clock per accepted command.
- R8: While busy, every write is ignored except data 0xB0, which issues start with start_cmd=2 (suspend) and sets mode=3. This happens at most once per busy period.
- R9: rb_pull_en is high exactly while busy, eng_susp=0 and eng_pd=0, whatever the values of ce_n and oe_n. When eng_done is sampled high while busy, the block leaves the busy state on that edge and sets mode to read (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| low_vcc | input | 1 | Supply below lockout level |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus write data |
| eng_done | input | 1 | Engine finished its operation |
| eng_susp | input | 1 | Engine is in erase suspend |
| eng_pd | input | 1 | Engine is in deep power-down |
| start | output | 1 | One-clock start pulse to the engine |
| start_cmd | output | 2 | Command type carried with start: 0 program, 1 erase, 2 suspend |
| mode | output | 2 | Mode: 0 read, 1 program, 2 erase, 3 suspended |
| rb_pull_en | output | 1 | Pull the shared ready/busy line low |

## Verification
The hardest state to reach from the ports is a write cycle interleaved with another event: a suspend byte arriving during a busy period, a lockout pulse in the middle of a partly entered unlock sequence, or a glitch-length strobe placed between two valid unlock steps. Directed cases build each of these one at a time. A seeded random phase then mixes writes of random length and random address and data with engine-done and lockout pulses. The random addresses and data are drawn mostly from the unlock and command values, so that partial and broken sequences occur often. After every event the start count, the mode and ready/busy are compared against a reference model kept in the bench.

// File: rtl/fwg_pkg.sv
// Shared types and command constants for the flash write-gating controller.
package fwg_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_SUSP  = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        CMD_PROG  = 2'd0,
        CMD_ERASE = 2'd1,
        CMD_SUSP  = 2'd2
    } cmd_t;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_KEY1 = 2'd1,
        STEP_KEY2 = 2'd2
    } step_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_BYTE_A = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_B = 8'h55;
    localparam logic [7:0]  OP_PROG    = 8'hA0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_SUSP    = 8'hB0;
    localparam logic [7:0]  OP_RESET   = 8'hF0;
endpackage

// File: rtl/fwg_strobe_qual.sv
// Strobe qualifier: turns sampled ce_n/we_n/oe_n into single-cycle write
// events. A write needs the qualifying level for GLITCH_CYC samples in a row.
// Assumes the strobes are already synchronous to clk. ADDR_W >= 15.
module fwg_strobe_qual #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              low_vcc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(GLITCH_CYC);

    logic             qual;
    logic [CNT_W-1:0] width_cnt;

    assign qual = ~ce_n & ~we_n & oe_n & ~low_vcc;

    // Count consecutive qualifying samples, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                      width_cnt <= '0;
        else if (!qual)                  width_cnt <= '0;
        else if (width_cnt != CNT_FULL)  width_cnt <= width_cnt + 1'b1;
    end

    // Hold address and data from the latest qualifying sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (qual) begin
            wr_addr <= addr;
            wr_data <= data;
        end
    end

    // Emit the write event when a long-enough strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_valid <= 1'b0;
        else        wr_valid <= ~qual & ~low_vcc & (width_cnt == CNT_FULL);
    end
endmodule

// File: rtl/fwg_cmd_seq.sv
// Command sequencer: walks the three-step unlock, issues the start pulse,
// keeps the mode register and the busy state. Lockout beats engine done,
// which beats writes.
module fwg_cmd_seq
    import fwg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_vcc,
    input  logic              eng_done,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              start,
    output cmd_t              start_cmd,
    output mode_t             mode,
    output logic              busy
);
    step_t step;
    logic  at_key_a, at_key_b;

    assign at_key_a = (wr_addr == ADDR_W'(KEY_ADDR_A));
    assign at_key_b = (wr_addr == ADDR_W'(KEY_ADDR_B));

    // Sequence, busy and mode update; start defaults low every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= STEP_IDLE;
            busy      <= 1'b0;
            mode      <= MODE_READ;
            start     <= 1'b0;
            start_cmd <= CMD_PROG;
        end else begin
            start <= 1'b0;
            if (low_vcc) begin
                step <= STEP_IDLE;
                busy <= 1'b0;
                mode <= MODE_READ;
            end else if (busy) begin
                if (eng_done) begin
                    busy <= 1'b0;
                    mode <= MODE_READ;
                end else if (wr_valid && wr_data == DATA_W'(OP_SUSP) && mode != MODE_SUSP) begin
                    start     <= 1'b1;
                    start_cmd <= CMD_SUSP;
                    mode      <= MODE_SUSP;
                end
            end else if (wr_valid) begin
                unique case (step)
                    STEP_IDLE: step <= (at_key_a && wr_data == DATA_W'(KEY_BYTE_A)) ? STEP_KEY1 : STEP_IDLE;
                    STEP_KEY1: step <= (at_key_b && wr_data == DATA_W'(KEY_BYTE_B)) ? STEP_KEY2 : STEP_IDLE;
                    default: begin
                        step <= STEP_IDLE;
                        if (at_key_a) begin
                            if (wr_data == DATA_W'(OP_PROG)) begin
                                start     <= 1'b1;
                                start_cmd <= CMD_PROG;
                                mode      <= MODE_PROG;
                                busy      <= 1'b1;
                            end else if (wr_data == DATA_W'(OP_ERASE)) begin
                                start     <= 1'b1;
                                start_cmd <= CMD_ERASE;
                                mode      <= MODE_ERASE;
                                busy      <= 1'b1;
                            end else if (wr_data == DATA_W'(OP_RESET)) begin
                                mode      <= MODE_READ;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/fwg_rb_drive.sv
// Ready/busy driver: pull-low enable for an open-drain line. It depends only
// on the busy state and the engine's suspend and power-down flags, never on
// the chip or output enables.
module fwg_rb_drive (
    input  logic busy,
    input  logic eng_susp,
    input  logic eng_pd,
    output logic rb_pull_en
);
    // Pull low only while an operation is actually running.
    always_comb rb_pull_en = busy & ~eng_susp & ~eng_pd;
endmodule

// File: rtl/flash_wr_gate.sv
// Top of the flash write-gating and ready/busy controller. Chains the strobe
// qualifier, the command sequencer and the ready/busy driver.
module flash_wr_gate #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              low_vcc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              eng_done,
    input  logic              eng_susp,
    input  logic              eng_pd,
    output logic              start,
    output logic [1:0]        start_cmd,
    output logic [1:0]        mode,
    output logic              rb_pull_en
);
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              busy;
    fwg_pkg::cmd_t     cmd_q;
    fwg_pkg::mode_t    mode_q;

    fwg_strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .low_vcc(low_vcc), .addr(addr), .data(data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fwg_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .low_vcc(low_vcc), .eng_done(eng_done),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .start_cmd(cmd_q), .mode(mode_q), .busy(busy)
    );

    fwg_rb_drive u_rb (
        .busy(busy), .eng_susp(eng_susp), .eng_pd(eng_pd), .rb_pull_en(rb_pull_en)
    );

    assign start_cmd = cmd_q;
    assign mode      = mode_q;
endmodule

// File: rtl/fwg_checker.sv
// Protocol checker for flash_wr_gate, attached with bind.
module fwg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       low_vcc,
    input logic       eng_done,
    input logic       eng_susp,
    input logic       eng_pd,
    input logic       start,
    input logic [1:0] start_cmd,
    input logic [1:0] mode,
    input logic       rb_pull_en
);
    assert_reset_read_R4: assert property (@(posedge clk)
        !rst_n |=> (mode == 2'd0 && !start && !rb_pull_en));

    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_vcc |=> (mode == 2'd0 && !start && !rb_pull_en));

    assert_rb_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_susp || eng_pd) |-> !rb_pull_en);

    assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_pull_en && eng_done && !low_vcc) |=> !rb_pull_en);

    assert_cmd_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> start_cmd != 2'd3);

    assert_prog_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_cmd != 2'd2 && !eng_susp && !eng_pd) |-> rb_pull_en);

    assert_susp_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_cmd == 2'd2) |-> mode == 2'd3);
endmodule

bind flash_wr_gate fwg_checker chk (
    .clk(clk), .rst_n(rst_n), .low_vcc(low_vcc), .eng_done(eng_done),
    .eng_susp(eng_susp), .eng_pd(eng_pd), .start(start), .start_cmd(start_cmd),
    .mode(mode), .rb_pull_en(rb_pull_en)
);

// File: tb/flash_wr_gate_test.sv
`timescale 1ns/1ps
module flash_wr_gate_test;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int GC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, low_vcc = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          eng_done = 1'b0, eng_susp = 1'b0, eng_pd = 1'b0;
    logic          start, rb_pull_en;
    logic [1:0]    start_cmd, mode;

    flash_wr_gate #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .low_vcc(low_vcc), .addr(addr), .data(data), .eng_done(eng_done),
        .eng_susp(eng_susp), .eng_pd(eng_pd), .start(start),
        .start_cmd(start_cmd), .mode(mode), .rb_pull_en(rb_pull_en)
    );

    always #4 clk = ~clk;

    int errors = 0, checks = 0;
    bit finished = 0;

    // Start-pulse monitor, sampled away from the active edge.
    int starts = 0, run = 0, max_run = 0;
    logic [1:0] seen_cmd = 2'd0;
    always @(negedge clk) begin
        if (start === 1'b1) begin
            starts++; seen_cmd = start_cmd; run++;
            if (run > max_run) max_run = run;
        end else run = 0;
    end

    // Reference model.
    int m_step = 0, m_starts = 0;
    bit m_busy = 0;
    int m_mode = 0, m_cmd = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rb();
        return (m_busy && !eng_susp && !eng_pd) ? 1 : 0;
    endfunction

    task automatic compare(string tag);
        check({tag, " start count (R5)"}, starts, m_starts);
        check({tag, " mode (R5)"}, int'(mode), m_mode);
        check({tag, " ready/busy (R9)"}, int'(rb_pull_en), exp_rb());
    endtask

    task automatic model_write(int a, int d);
        if (m_busy) begin
            if (d == 'hB0 && m_mode != 3) begin m_starts++; m_cmd = 2; m_mode = 3; end
        end else if (m_step == 0) m_step = (a == 'h5555 && d == 'hAA) ? 1 : 0;
        else if (m_step == 1) m_step = (a == 'h2AAA && d == 'h55) ? 2 : 0;
        else begin
            m_step = 0;
            if (a == 'h5555) begin
                if (d == 'hA0) begin m_starts++; m_cmd = 0; m_mode = 1; m_busy = 1; end
                else if (d == 'h80) begin m_starts++; m_cmd = 1; m_mode = 2; m_busy = 1; end
                else if (d == 'hF0) m_mode = 0;
            end
        end
    endtask

    // One bus cycle with given strobe levels held for len samples.
    task automatic cyc(int a, int d, int len, bit cev, bit wev, bit oev);
        @(negedge clk);
        ce_n = cev; we_n = wev; oe_n = oev; addr = AW'(a); data = DW'(d);
        repeat (len) @(posedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        if (!cev && !wev && oev && len >= GC && !low_vcc) model_write(a, d);
    endtask

    task automatic wr(int a, int d, int len);
        cyc(a, d, len, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic unlock_cmd(int op);
        wr('h5555, 'hAA, GC); wr('h2AAA, 'h55, GC); wr('h5555, op, GC);
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        if (!low_vcc && m_busy) begin m_busy = 0; m_mode = 0; end
        @(negedge clk);
    endtask

    task automatic lockout_pulse();
        @(negedge clk); low_vcc = 1'b1;
        m_step = 0; m_busy = 0; m_mode = 0;
        repeat (2) @(negedge clk);
        low_vcc = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired (all requirements)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 mode after reset", int'(mode), 0);
        check("R4 start after reset", int'(start), 0);
        check("R4 rb after reset", int'(rb_pull_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: program sequence
        unlock_cmd('hA0);
        compare("R5 program");
        check("R5 program start_cmd", int'(seen_cmd), 0);
        // R8: writes while busy are ignored
        unlock_cmd('h80);
        compare("R8 busy ignores sequence");
        // R9: done releases ready/busy
        done_pulse();
        compare("R9 after done");

        // R2: glitch on first step means sequence never starts
        wr('h5555, 'hAA, GC - 1); wr('h2AAA, 'h55, GC); wr('h5555, 'h80, GC);
        compare("R2 glitch rejected");
        // R2: longer pulse accepted, erase command
        wr('h5555, 'hAA, GC + 2); wr('h2AAA, 'h55, GC + 1); wr('h5555, 'h80, GC);
        compare("R2 long strobe erase");
        check("R5 erase start_cmd", int'(seen_cmd), 1);

        // R8: suspend while busy
        wr('h1234, 'hB0, GC);
        compare("R8 suspend");
        check("R8 suspend start_cmd", int'(seen_cmd), 2);
        wr('h1234, 'hB0, GC);
        compare("R8 second suspend ignored");
        // R9: released during suspend and power-down, indifferent to ce/oe
        @(negedge clk); eng_susp = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); check("R9 rb during suspend", int'(rb_pull_en), 0);
        eng_susp = 1'b0;
        @(negedge clk); check("R9 rb with ce/oe low", int'(rb_pull_en), 1);
        eng_pd = 1'b1;
        @(negedge clk); check("R9 rb in power-down", int'(rb_pull_en), 0);
        eng_pd = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        done_pulse();
        compare("R9 done after suspend");

        // R6: out-of-order cycle aborts
        wr('h5555, 'hAA, GC); wr('h2AAA, 'hAA, GC); wr('h2AAA, 'h55, GC); wr('h5555, 'hA0, GC);
        compare("R6 out-of-order");
        unlock_cmd('h33);
        compare("R6 unknown command");
        unlock_cmd('hF0); wr('h5555, 'hA0, GC);
        compare("R6 reset command");

        // R1: oe low or ce high on last step blocks the write
        wr('h5555, 'hAA, GC); wr('h2AAA, 'h55, GC);
        cyc('h5555, 'hA0, GC, 1'b0, 1'b0, 1'b0);
        compare("R1 oe low blocks");
        cyc('h5555, 'hA0, GC, 1'b1, 1'b0, 1'b1);
        compare("R1 ce high blocks");
        wr('h5555, 'hA0, GC);
        compare("R1 after blocked cycles");

        // R3: lockout clears busy and partial sequence, ignores writes
        unlock_cmd('hA0);
        lockout_pulse();
        compare("R3 lockout clears busy");
        wr('h5555, 'hAA, GC); wr('h2AAA, 'h55, GC);
        lockout_pulse();
        wr('h5555, 'hA0, GC);
        compare("R3 lockout aborts sequence");
        @(negedge clk); low_vcc = 1'b1;
        wr('h5555, 'hAA, GC); wr('h2AAA, 'h55, GC); wr('h5555, 'hA0, GC);
        compare("R3 writes ignored in lockout");
        @(negedge clk); low_vcc = 1'b0;
        repeat (2) @(negedge clk);

        // Random phase (R1 R2 R3 R5 R6 R8 R9)
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 9));
            if (op == 0) done_pulse();
            else if (op == 1) lockout_pulse();
            else begin
                int sa = int'($urandom_range(0, 3));
                int sd = int'($urandom_range(0, 7));
                int a = (sa == 0 || sa == 3) ? 'h5555 : (sa == 1 ? 'h2AAA : int'($urandom_range(0, 'hFFFF)));
                int d;
                case (sd)
                    0: d = 'hAA; 1: d = 'h55; 2: d = 'hA0; 3: d = 'h80;
                    4: d = 'hB0; 5: d = 'hF0; 6: d = 'hAA;
                    default: d = int'($urandom_range(0, 255));
                endcase
                wr(a, d, int'($urandom_range(1, 3)));
            end
            compare("random");
        end
        check("R7 start width", max_run, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule